// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of an asynchronous parallel flash bus. After software or another engine has sent a program or erase command to the flash, this block waits for the internal operation to finish. A one-cycle `start` pulse latches a target address, the byte that should now be stored there, and a limit on the number of polls. The block then holds chip enable low and issues a series of separate output-enable read strobes. Each strobe has a low time and a minimum high gap that are set by parameters in clock cycles, so they can be matched to the flash access time.

While the flash is busy, status bit 6 of the data bus changes value on every access. The block compares that bit between each read and the read before it. When the bit is the same twice in a row, the operation is over. The byte from that comparing read is not trusted, because the other data bits can settle after the status bits. The block therefore issues one further read and reports that byte. It also flags the byte if it differs from the expected value. If the status bit is still changing when the poll limit is reached, the block stops and reports a timeout.

Top module: `flash_toggle_poller`

## Requirements
- R1: During and right after reset, `fl_oe_n` and `fl_ce_n` are high, and `busy`, `done`, `timeout` and `data_err` are low.
- R2: A `start` pulse while idle latches `tgt_addr`, `exp_byte` and `poll_limit`. In the next cycle `busy` is high and `fl_ce_n` is low. `fl_addr` then holds the latched address for the whole job. `busy` falls in the same cycle that `done` or `timeout` rises.
- R3: Every read is one `fl_oe_n` low pulse of exactly LOW_CYC cycles. Consecutive pulses within a job are separated by at least GAP_CYC high cycles. `fl_oe_n` is low only while `fl_ce_n` is low.
- R4: The first read of a job only records bit 6 of `fl_dq`. A later read whose bit 6 differs from that of the read before it counts as one poll, and another read follows.
- R5: When bit 6 of a read equals bit 6 of the previous read, exactly one more read is issued. The full byte of that extra read is reported on `final_byte`; the byte of the comparing read is never reported.
- R6: `done` is a one-cycle pulse after the extra read. At that point `data_err` is set to (`final_byte` != latched expected byte). Both `data_err` and `final_byte` hold until the next start.
- R7: If the poll that brings the poll count to `poll_limit` still sees bit 6 changing, `timeout` pulses for one cycle, no more reads are issued, and `done` does not pulse. A limit of 0 acts as 1.
- R8: A `start` pulse while `busy` is high is ignored: the address, the read sequence and the result of the running job are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin waiting |
| tgt_addr | input | AW | Address to poll |
| exp_byte | input | 8 | Byte expected once the operation ends |
| poll_limit | input | PW | Maximum number of polls before timeout |
| fl_addr | output | AW | Flash address bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable (read strobe), active low |
| fl_dq | input | 8 | Flash data bus, bit 6 is the toggle status |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: operation finished, final byte valid |
| timeout | output | 1 | One-cycle pulse: poll limit reached while still toggling |
| data_err | output | 1 | Final byte differs from the expected byte |
| final_byte | output | 8 | Byte from the confirming read |

## Verification
The assertions assume `start` is synchronous to `clk` and that `fl_dq` is stable from the middle of the first low cycle of each strobe until the sampling edge at the end of the strobe. The bench's flash model meets this by changing `fl_dq` only on the falling clock edge after it sees a new strobe begin. The model answers each access in order: a number of busy status bytes whose bit 6 alternates, then one byte with unsettled low bits, then the settled byte. This lets the sweep over busy lengths, poll limits and data patterns reach every completion and timeout path while keeping the bus inside those assumptions.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int DQ_W     = 8;
    localparam int STAT_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_GAP
    } strobe_e;

    typedef enum logic [1:0] {
        J_IDLE,
        J_FIRST,
        J_POLL,
        J_FINAL
    } job_e;

    typedef enum logic [1:0] {
        ACT_POLL_AGAIN,
        ACT_CONFIRM,
        ACT_FINISH,
        ACT_GIVE_UP
    } act_e;

    typedef struct packed {
        logic [DQ_W-1:0] expect_b;
        logic            ref_bit;
    } job_ctx_t;

    function automatic logic status_of(input logic [DQ_W-1:0] b);
        return b[STAT_BIT];
    endfunction

endpackage

// File: rtl/flash_strobe_timer.sv
module flash_strobe_timer
    import flash_poll_pkg::*;
#(
    parameter int LOW_CYC = 8,
    parameter int GAP_CYC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [DQ_W-1:0] dq,
    output logic            oe_n,
    output logic [DQ_W-1:0] rd_data,
    output logic            rd_done
);
    localparam int MAXC = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    strobe_e       st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            rd_data <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    st  <= ST_LOW;
                    cnt <= CW'(LOW_CYC - 1);
                end
                ST_LOW: if (cnt == '0) begin
                    rd_data <= dq;
                    st      <= ST_GAP;
                    cnt     <= CW'(GAP_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_GAP: if (cnt == '0) begin
                    st <= ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign oe_n    = (st != ST_LOW);
    assign rd_done = (st == ST_GAP) && (cnt == '0);

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
    import flash_poll_pkg::*;
#(
    parameter int PW = 8
) (
    input  job_e          phase,
    input  logic          cur_bit,
    input  logic          ref_bit,
    input  logic [PW-1:0] polls,
    input  logic [PW-1:0] limit,
    output act_e          act
);
    logic [PW:0] polls_after;

    always_comb begin
        polls_after = {1'b0, polls} + 1'b1;
        act         = ACT_POLL_AGAIN;
        case (phase)
            J_FIRST: act = ACT_POLL_AGAIN;
            J_POLL: begin
                if (cur_bit == ref_bit)
                    act = ACT_CONFIRM;
                else if (polls_after >= {1'b0, limit})
                    act = ACT_GIVE_UP;
                else
                    act = ACT_POLL_AGAIN;
            end
            J_FINAL: act = ACT_FINISH;
            default: act = ACT_POLL_AGAIN;
        endcase
    end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import flash_poll_pkg::*;
#(
    parameter int AW      = 17,
    parameter int PW      = 8,
    parameter int LOW_CYC = 8,
    parameter int GAP_CYC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [DQ_W-1:0] exp_byte,
    input  logic [PW-1:0]   poll_limit,
    output logic [AW-1:0]   fl_addr,
    output logic            fl_ce_n,
    output logic            fl_oe_n,
    input  logic [DQ_W-1:0] fl_dq,
    output logic            busy,
    output logic            done,
    output logic            timeout,
    output logic            data_err,
    output logic [DQ_W-1:0] final_byte
);
    job_e            phase;
    job_ctx_t        ctx;
    logic [PW-1:0]   polls;
    logic [PW-1:0]   limit_q;
    logic [AW-1:0]   addr_q;
    logic [DQ_W-1:0] rd_data;
    logic            rd_done;
    act_e            act;

    flash_strobe_timer #(
        .LOW_CYC(LOW_CYC),
        .GAP_CYC(GAP_CYC)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .go     (phase != J_IDLE),
        .dq     (fl_dq),
        .oe_n   (fl_oe_n),
        .rd_data(rd_data),
        .rd_done(rd_done)
    );

    flash_poll_judge #(
        .PW(PW)
    ) u_judge (
        .phase  (phase),
        .cur_bit(status_of(rd_data)),
        .ref_bit(ctx.ref_bit),
        .polls  (polls),
        .limit  (limit_q),
        .act    (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= J_IDLE;
            ctx        <= '0;
            polls      <= '0;
            limit_q    <= '0;
            addr_q     <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
            data_err   <= 1'b0;
            final_byte <= '0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            if (phase == J_IDLE) begin
                if (start) begin
                    phase        <= J_FIRST;
                    addr_q       <= tgt_addr;
                    limit_q      <= poll_limit;
                    ctx.expect_b <= exp_byte;
                    polls        <= '0;
                    data_err     <= 1'b0;
                end
            end else if (rd_done) begin
                case (act)
                    ACT_POLL_AGAIN: begin
                        ctx.ref_bit <= status_of(rd_data);
                        if (phase == J_POLL)
                            polls <= polls + 1'b1;
                        phase <= J_POLL;
                    end
                    ACT_CONFIRM: phase <= J_FINAL;
                    ACT_FINISH: begin
                        phase      <= J_IDLE;
                        done       <= 1'b1;
                        final_byte <= rd_data;
                        data_err   <= (rd_data != ctx.expect_b);
                    end
                    ACT_GIVE_UP: begin
                        phase   <= J_IDLE;
                        timeout <= 1'b1;
                    end
                    default: phase <= J_IDLE;
                endcase
            end
        end
    end

    assign busy    = (phase != J_IDLE);
    assign fl_ce_n = ~busy;
    assign fl_addr = addr_q;

endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
    parameter int AW      = 17,
    parameter int LOW_CYC = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input logic          fl_oe_n,
    input logic          fl_ce_n,
    input logic [AW-1:0] fl_addr
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)           low_run <= '0;
        else if (!fl_oe_n) low_run <= low_run + 1'b1;
        else               low_run <= '0;
    end

    assert_strobe_in_select_R3: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_ce_n);

    assert_low_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_oe_n) |-> (low_run == 16'(LOW_CYC)));

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fl_addr));

    assert_end_drops_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !timeout && $past(busy)));

    assert_timeout_ends_job_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (!busy && $past(busy)));

endmodule

bind flash_toggle_poller flash_poll_chk #(
    .AW     (AW),
    .LOW_CYC(LOW_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .timeout(timeout),
    .fl_oe_n(fl_oe_n),
    .fl_ce_n(fl_ce_n),
    .fl_addr(fl_addr)
);

// File: tb/sim_flash_toggle_poller.sv
module sim_flash_toggle_poller;
    localparam int AW      = 17;
    localparam int PW      = 8;
    localparam int LOW_CYC = 8;
    localparam int GAP_CYC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0]    exp_byte = '0;
    logic [PW-1:0] poll_limit = '0;
    logic [AW-1:0] fl_addr;
    logic          fl_ce_n, fl_oe_n;
    logic [7:0]    fl_dq = 8'h00;
    logic          busy, done, timeout, data_err;
    logic [7:0]    final_byte;

    int n_tests = 0;
    int n_fail  = 0;

    // flash model state
    int            busy_reads = 0;
    logic [7:0]    data_v = 8'h00;
    int            rd_idx = 0;
    logic          prev_oe = 1'b1;
    int            low_len = 0;
    int            gap_len = 0;
    logic          seen_one = 1'b0;
    int            width_err = 0;
    int            addr_err = 0;
    logic [AW-1:0] want_addr = '0;

    always #5 clk = ~clk;

    flash_toggle_poller #(
        .AW(AW), .PW(PW), .LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .tgt_addr(tgt_addr),
        .exp_byte(exp_byte), .poll_limit(poll_limit), .fl_addr(fl_addr),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_dq(fl_dq), .busy(busy),
        .done(done), .timeout(timeout), .data_err(data_err),
        .final_byte(final_byte)
    );

    function automatic logic [7:0] byte_at(input int r, input int k, input logic [7:0] d);
        if (r <= k)          return {~d[7], r[0], 6'h2A};
        else if (r == k + 1) return {d[7:6], ~d[5:0]};
        else                 return d;
    endfunction

    always @(negedge clk) begin
        if (prev_oe && !fl_oe_n) begin
            rd_idx = rd_idx + 1;
            fl_dq  = byte_at(rd_idx, busy_reads, data_v);
            if (seen_one && gap_len < GAP_CYC) width_err = width_err + 1;
            if (fl_addr !== want_addr) addr_err = addr_err + 1;
            seen_one = 1'b1;
            low_len  = 1;
        end else if (!fl_oe_n) begin
            low_len = low_len + 1;
        end else if (!prev_oe && fl_oe_n) begin
            if (low_len != LOW_CYC) width_err = width_err + 1;
            gap_len = 1;
        end else begin
            gap_len = gap_len + 1;
        end
        prev_oe = fl_oe_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_job(input int k, input int lim, input logic [7:0] d,
                           input logic [7:0] ex, input logic [AW-1:0] a,
                           input bit poke_busy);
        int  lim_eff, i, exp_reads, waited;
        bit  exp_done, got_done, got_to, got_busy_ok;
        // expected outcome from the requirements
        lim_eff = (lim == 0) ? 1 : lim;
        exp_done = 1'b0;
        exp_reads = lim_eff + 1;
        for (int r = 2; r <= k + 3; r++) begin
            if (byte_at(r, k, d)[6] == byte_at(r - 1, k, d)[6]) begin
                if (r - 1 <= lim_eff) begin
                    exp_done  = 1'b1;
                    exp_reads = r + 1;
                end
                break;
            end
        end
        i = 0;
        busy_reads = k; data_v = d; rd_idx = 0; seen_one = 1'b0;
        width_err = 0; addr_err = 0; want_addr = a;
        @(negedge clk);
        tgt_addr = a; exp_byte = ex; poll_limit = PW'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0; tgt_addr = ~a; exp_byte = ~ex;
        got_busy_ok = busy && !fl_ce_n;
        check(got_busy_ok, "R2 busy/ce after start", busy, 1);
        got_done = 1'b0; got_to = 1'b0; waited = 0;
        while (!done && !timeout && waited < 4000) begin
            if (poke_busy && waited == 20) begin
                tgt_addr = a ^ 17'h155; poll_limit = 8'd1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end else begin
                @(negedge clk);
            end
            waited++;
        end
        got_done = done; got_to = timeout;
        if (waited >= 4000) check(1'b0, "R7 watchdog job hung", waited, 0);
        check(!busy, "R2 busy low at end", busy, 0);
        if (exp_done) begin
            check(got_done && !got_to, "R5 completion detected", got_to, 0);
            check(final_byte == d, "R5 final byte from extra read", final_byte, d);
            check(data_err == (d != ex), "R6 data_err compare", data_err, d != ex);
        end else begin
            check(got_to && !got_done, "R7 timeout raised", got_done, 0);
        end
        check(rd_idx == exp_reads, "R4 read strobe count", rd_idx, exp_reads);
        check(width_err == 0, "R3 strobe width/gap", width_err, 0);
        check(addr_err == 0, "R2 address held", addr_err, 0);
        // after end: no further strobes, flags were single pulses
        @(negedge clk);
        check(!done && !timeout, "R6 flags are one-cycle pulses", done, 0);
        repeat (LOW_CYC + GAP_CYC + 2) @(negedge clk);
        check(rd_idx == exp_reads && fl_oe_n, "R7 no reads after end", rd_idx, exp_reads);
        if (exp_done)
            check(final_byte == d && data_err == (d != ex), "R6 results held", final_byte, d);
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] pats [3];
        pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'hC3;
        repeat (3) @(negedge clk);
        check(fl_oe_n && fl_ce_n && !busy && !done && !timeout && !data_err,
              "R1 reset state", {fl_oe_n, fl_ce_n, busy, done, timeout}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        check(fl_oe_n && fl_ce_n && !busy && !done && !timeout,
              "R1 idle after reset", {fl_oe_n, fl_ce_n, busy}, 3'b110);
        for (int k = 0; k <= 6; k++)
            for (int lim = 0; lim <= 5; lim++)
                for (int p = 0; p < 3; p++)
                    run_job(k, lim, pats[p], (p == 2) ? (pats[p] ^ 8'h01) : pats[p],
                            AW'(k * 64 + lim * 8 + p + 17'h10000), 1'b0);
        // R8: start pulse during a running job is ignored
        run_job(3, 6, 8'h5A, 8'h5A, 17'h0ABCD, 1'b1);
        run_job(5, 2, 8'h1E, 8'h1E, 17'h13579, 1'b1);
        check(1'b1, "R8 mid-job start ignored (checked via address, reads, result)", 1, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule